// File: doc/BRIEF.md
# Code/Data Memory Access Steering Unit

This block sits between an 8051-style core and two backing stores: a read-only program array (one-time programmable, modelled here as a computed pattern) and a small synchronous RAM. Both stores appear in the code space and in the external data space. Each request carries a 16-bit address and an access type. The type is instruction fetch, code-space read (MOVC), data-space read (MOVX read) or data-space write (MOVX write). The unit picks the store that serves the request and returns the read byte one cycle later, together with a valid strobe.

Instruction fetches go to whichever store's window holds the address. Each fetch that hits a store also records whether the core is now running out of RAM. Code-space reads only ever see the program array. Data-space accesses are steered by where the current instruction came from, not by address alone. When running from the program array, MOVX reaches the RAM. When running from RAM, MOVX reads reach the program array, and MOVX writes, which would land in the program array, are discarded and flagged. An address outside the chosen store's window reads as 0xFF and raises a one-cycle decode error.

Top module: `memsteer_top`

## Requirements
- R1: An instruction fetch (type code 0) inside the program window (0x0000–0x3FFF) returns program data. A fetch inside the RAM window (0x8000–0x87FF) returns RAM data. Such a fetch sets the execute-from-RAM state to the store that served it.
- R2: A code read (type code 1) returns program-array data when the address is in the program window. It never returns RAM data. A code read in the RAM window returns 0xFF with a decode error.
- R3: While executing from RAM, a data read (type code 2) is served from the program array. An address outside the program window returns 0xFF with a decode error.
- R4: While executing from the program array, data reads and data writes (type code 3) are served from the RAM window. A data read outside the RAM window returns 0xFF with a decode error.
- R5: A data write while executing from RAM changes no RAM byte and raises the write-violation output for exactly one cycle, one cycle after the request.
- R6: An out-of-window access returns 0xFF and raises the decode-error output for exactly one cycle, one cycle after the request.
- R7: Valid is high exactly in the cycle after each request, and low otherwise.
- R8: After reset the unit executes from the program array, and valid, decode error and write violation are low.
- R9: A fetch that hits no window leaves the execute-from-RAM state unchanged. So do code and data accesses.
- R10: The program byte at offset a from the program base reads as a[7:0] XOR a[15:8] XOR 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one cycle per access |
| acc_type_i | input | 2 | Access type: 0 fetch, 1 code read, 2 data read, 3 data write |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data for data writes |
| rdata_o | output | 8 | Read byte, meaningful while valid is high |
| valid_o | output | 1 | Response strobe, one cycle after a request |
| dec_err_o | output | 1 | Out-of-window access pulse |
| wr_viol_o | output | 1 | Dropped write to the program array pulse |

## Verification
The only hidden state is the execute-from-RAM flag. A wrong value shows up at the next data access: a MOVX read returns a RAM byte in place of a program byte or the reverse, or a write is flagged where it should land. Checks therefore follow every fetch, failed fetch and data access with a MOVX read whose two possible answers differ. A mistaken RAM write stays hidden until a later read of that byte, so the bench reads back the guarded location after switching execution to the program array.

// File: rtl/memsteer_pkg.sv
package memsteer_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH   = 2'd0,
        ACC_CODE_RD = 2'd1,
        ACC_DATA_RD = 2'd2,
        ACC_DATA_WR = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_OTP  = 2'd1,
        SRC_RAM  = 2'd2
    } src_e;

    typedef struct packed {
        logic exec_ram;
        logic valid;
        src_e src;
        logic err;
        logic wviol;
    } steer_state_t;

endpackage

// File: rtl/memsteer_decode.sv
module memsteer_decode
    import memsteer_pkg::*;
#(
    parameter int OTP_BASE = 16'h0000,
    parameter int OTP_SIZE = 16'h4000,
    parameter int RAM_BASE = 16'h8000,
    parameter int RAM_SIZE = 16'h0800
) (
    input  logic        req,
    input  acc_e        acc,
    input  logic [15:0] addr,
    input  logic        exec_ram,
    output src_e        src,
    output logic        ram_we,
    output logic        err,
    output logic        wviol
);
    localparam logic [16:0] OtpLo = 17'(OTP_BASE);
    localparam logic [16:0] OtpHi = 17'(OTP_BASE + OTP_SIZE);
    localparam logic [16:0] RamLo = 17'(RAM_BASE);
    localparam logic [16:0] RamHi = 17'(RAM_BASE + RAM_SIZE);

    logic [16:0] a_ext;
    logic        in_otp;
    logic        in_ram;

    always_comb begin
        a_ext  = {1'b0, addr};
        in_otp = (a_ext >= OtpLo) && (a_ext < OtpHi);
        in_ram = (a_ext >= RamLo) && (a_ext < RamHi);

        src    = SRC_NONE;
        ram_we = 1'b0;
        err    = 1'b0;
        wviol  = 1'b0;

        if (req) begin
            unique case (acc)
                ACC_FETCH: begin
                    if (in_otp)      src = SRC_OTP;
                    else if (in_ram) src = SRC_RAM;
                    else             err = 1'b1;
                end
                ACC_CODE_RD: begin
                    if (in_otp) src = SRC_OTP;
                    else        err = 1'b1;
                end
                ACC_DATA_RD: begin
                    if (exec_ram) begin
                        if (in_otp) src = SRC_OTP;
                        else        err = 1'b1;
                    end else begin
                        if (in_ram) src = SRC_RAM;
                        else        err = 1'b1;
                    end
                end
                ACC_DATA_WR: begin
                    if (exec_ram)    wviol  = 1'b1;
                    else if (in_ram) ram_we = 1'b1;
                    else             err    = 1'b1;
                end
                default: err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/memsteer_otp.sv
module memsteer_otp #(
    parameter int OTP_BASE = 16'h0000
) (
    input  logic        clk,
    input  logic        en,
    input  logic [15:0] addr,
    output logic [7:0]  dout
);
    logic [15:0] off;
    logic [7:0]  dout_d, dout_q;

    always_comb begin
        off    = addr - 16'(OTP_BASE);
        dout_d = en ? (off[7:0] ^ off[15:8] ^ 8'h5A) : dout_q;
    end

    always_ff @(posedge clk) begin
        dout_q <= dout_d;
    end

    assign dout = dout_q;
endmodule

// File: rtl/memsteer_ram.sv
module memsteer_ram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    dout
);
    localparam int Depth = 1 << AW;

    logic [7:0] mem [Depth];
    logic [7:0] dout_q;

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        if (re) dout_q <= mem[idx];
    end

    assign dout = dout_q;
endmodule

// File: rtl/memsteer_top.sv
module memsteer_top
    import memsteer_pkg::*;
#(
    parameter int OTP_BASE = 16'h0000,
    parameter int OTP_SIZE = 16'h4000,
    parameter int RAM_BASE = 16'h8000,
    parameter int RAM_AW   = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic [1:0]  acc_type_i,
    input  logic [15:0] addr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic        valid_o,
    output logic        dec_err_o,
    output logic        wr_viol_o
);
    localparam int RamSize = 1 << RAM_AW;

    steer_state_t state_d, state_q;
    acc_e         acc;
    src_e         src;
    logic         ram_we, err, wviol;
    logic [RAM_AW-1:0] ram_idx;
    logic [7:0]   otp_dout, ram_dout;

    assign acc     = acc_e'(acc_type_i);
    assign ram_idx = RAM_AW'(addr_i - 16'(RAM_BASE));

    memsteer_decode #(
        .OTP_BASE(OTP_BASE), .OTP_SIZE(OTP_SIZE),
        .RAM_BASE(RAM_BASE), .RAM_SIZE(RamSize)
    ) decode_i (
        .req(req_i), .acc(acc), .addr(addr_i), .exec_ram(state_q.exec_ram),
        .src(src), .ram_we(ram_we), .err(err), .wviol(wviol)
    );

    memsteer_otp #(.OTP_BASE(OTP_BASE)) otp_i (
        .clk(clk), .en(src == SRC_OTP), .addr(addr_i), .dout(otp_dout)
    );

    memsteer_ram #(.AW(RAM_AW)) ram_i (
        .clk(clk), .re(src == SRC_RAM), .we(ram_we), .idx(ram_idx),
        .wdata(wdata_i), .dout(ram_dout)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_i;
        state_d.src   = src;
        state_d.err   = err;
        state_d.wviol = wviol;
        if (req_i && acc == ACC_FETCH && src != SRC_NONE)
            state_d.exec_ram = (src == SRC_RAM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{exec_ram: 1'b0, valid: 1'b0, src: SRC_NONE,
                         err: 1'b0, wviol: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q.src)
            SRC_OTP: rdata_o = otp_dout;
            SRC_RAM: rdata_o = ram_dout;
            default: rdata_o = 8'hFF;
        endcase
    end

    assign valid_o   = state_q.valid;
    assign dec_err_o = state_q.err;
    assign wr_viol_o = state_q.wviol;

    a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);
    a_r6_err_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |-> rdata_o == 8'hFF);
    a_r5_viol_from_movx_wr: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && acc == ACC_DATA_WR && state_q.exec_ram |=> wr_viol_o && !dec_err_o);
    a_r5_no_ram_write_exec_ram: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.exec_ram |-> !ram_we);
    a_r2_code_read_never_ram: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && acc == ACC_CODE_RD |=> state_q.src != SRC_RAM);
    a_r9_flag_moves_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && acc == ACC_FETCH) |=> $stable(state_q.exec_ram));
endmodule

// File: tb/memsteer_top_tb_top.sv
module memsteer_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  acc_type_i = 2'd0;
    logic [15:0] addr_i = 16'h0;
    logic [7:0]  wdata_i = 8'h0;
    logic [7:0]  rdata_o;
    logic        valid_o, dec_err_o, wr_viol_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memsteer_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .acc_type_i(acc_type_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .valid_o(valid_o), .dec_err_o(dec_err_o), .wr_viol_o(wr_viol_o)
    );

    function automatic logic [7:0] otp_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one request, return the response sampled one cycle later.
    task automatic access(input logic [1:0] t, input logic [15:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output logic v, output logic e, output logic w);
        @(negedge clk);
        req_i = 1'b1; acc_type_i = t; addr_i = a; wdata_i = wd;
        @(negedge clk);
        req_i = 1'b0;
        rd = rdata_o; v = valid_o; e = dec_err_o; w = wr_viol_o;
    endtask

    task automatic t_reset();
        chk("R8", "valid after reset", valid_o, 0);
        chk("R8", "err after reset", dec_err_o, 0);
        chk("R8", "viol after reset", wr_viol_o, 0);
    endtask

    task automatic t_otp_exec_data();
        logic [7:0] rd; logic v, e, w;
        access(2'd3, 16'h8010, 8'h3C, rd, v, e, w);
        chk("R4", "write valid", v, 1);
        chk("R5", "no viol when exec otp", w, 0);
        access(2'd2, 16'h8010, 8'h00, rd, v, e, w);
        chk("R4", "movx read ram data", rd, 8'h3C);
        chk("R7", "read valid", v, 1);
        access(2'd2, 16'h0040, 8'h00, rd, v, e, w);
        chk("R4", "movx read otp addr gives ff", rd, 8'hFF);
        chk("R4", "movx read otp addr err", e, 1);
        @(negedge clk);
        chk("R6", "err one cycle only", dec_err_o, 0);
        chk("R7", "no valid when idle", valid_o, 0);
    endtask

    task automatic t_code_reads();
        logic [7:0] rd; logic v, e, w;
        access(2'd1, 16'h0123, 8'h00, rd, v, e, w);
        chk("R10", "movc otp pattern", rd, otp_byte(16'h0123));
        chk("R2", "movc no err", e, 0);
        access(2'd1, 16'h3FFF, 8'h00, rd, v, e, w);
        chk("R2", "movc top of otp", rd, otp_byte(16'h3FFF));
        access(2'd1, 16'h8010, 8'h00, rd, v, e, w);
        chk("R2", "movc ram window ff", rd, 8'hFF);
        chk("R2", "movc ram window err", e, 1);
    endtask

    task automatic t_ram_exec();
        logic [7:0] rd; logic v, e, w;
        access(2'd0, 16'h8010, 8'h00, rd, v, e, w);
        chk("R1", "fetch from ram", rd, 8'h3C);
        access(2'd2, 16'h0040, 8'h00, rd, v, e, w);
        chk("R3", "movx read from otp when exec ram", rd, otp_byte(16'h0040));
        chk("R3", "no err", e, 0);
        access(2'd2, 16'h8010, 8'h00, rd, v, e, w);
        chk("R3", "movx read ram addr ff", rd, 8'hFF);
        chk("R3", "movx read ram addr err", e, 1);
        access(2'd3, 16'h8010, 8'h99, rd, v, e, w);
        chk("R5", "write viol pulse", w, 1);
        chk("R5", "write viol no err", e, 0);
        @(negedge clk);
        chk("R5", "viol one cycle", wr_viol_o, 0);
        access(2'd0, 16'h9000, 8'h00, rd, v, e, w);
        chk("R6", "bad fetch ff", rd, 8'hFF);
        chk("R6", "bad fetch err", e, 1);
        access(2'd2, 16'h0041, 8'h00, rd, v, e, w);
        chk("R9", "flag kept after bad fetch", rd, otp_byte(16'h0041));
    endtask

    task automatic t_back_to_otp();
        logic [7:0] rd; logic v, e, w;
        access(2'd0, 16'h0100, 8'h00, rd, v, e, w);
        chk("R1", "fetch from otp", rd, otp_byte(16'h0100));
        access(2'd2, 16'h8010, 8'h00, rd, v, e, w);
        chk("R5", "ram byte untouched by dropped write", rd, 8'h3C);
        access(2'd0, 16'h87FF, 8'h00, rd, v, e, w);
        chk("R1", "fetch at ram top no err", e, 0);
        access(2'd2, 16'h0042, 8'h00, rd, v, e, w);
        chk("R1", "exec flag now ram", rd, otp_byte(16'h0042));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_otp_exec_data();
        t_code_reads();
        t_ram_exec();
        t_back_to_otp();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule